// File: doc/BRIEF.md
# Deferred-Write Store Buffer for a Direct-Mapped Data Cache

This block is the store path of a small direct-mapped, write-allocate, write-through data cache whose tag array and data array have separate address ports. Every request checks its tag in the cycle it is presented. A store that hits does not write the data array in that cycle. Its address, data and byte mask are parked in a single pending entry, and that entry is written into the data array later. This happens in the data slot of the next store, or in any cycle in which the data array would otherwise sit unused. Because the tag check of one store and the data write of the previous one proceed together, stores never stall waiting for the buffer.

A load whose word and byte lanes overlap the pending entry is held for one cycle while the entry drains, and then it reads the array. A miss of either kind stalls for a fixed refill latency, reads the line from an internal next-level memory and writes it into the cache. A store miss merges its bytes into the refilled line as part of the miss handling. The store does not pass through the buffer. Lines are one 32-bit word, and addresses are word addresses.

The request channel is valid/ready. Once `req_valid` is high, the requester must hold it and all `req_*` fields steady until a clock edge where `req_ready` is also high. The requester must not withdraw a request that has been stalled. The load response channel has no back-pressure. The receiver must take `rsp_rdata` in the cycle `rsp_valid` is high.

Top module: `deferred_store_cache`

## Requirements
- R1: After reset, `req_ready` is high and `rsp_valid` is low with no request presented. Every cache line is invalid. Next-level memory word at address a holds a*0x01010101 (mod 2^32).
- R2: A load accepted at a clock edge produces `rsp_valid` high in the following cycle. Every byte lane selected by `req_be` holds the most recent value stored to that address and lane. Lane k is bits 8k+7..8k.
- R3: A store that hits is accepted in the cycle it is presented and becomes the pending entry at that edge.
- R4: Back-to-back stores that hit are each accepted with no stall. The older pending entry is written into the data array in the cycle the newer store is accepted.
- R5: A pending entry is written to the data array in any cycle with no request presented, so a later overlapping load does not stall.
- R6: A load to the pending entry's address whose `req_be` shares at least one lane with the entry's mask sees `req_ready` low for exactly one cycle, then is accepted and returns the stored data.
- R7: A load to the pending entry's address with no lane in common with the entry's mask is accepted with no stall.
- R8: A request that misses (index = address bits INDEX_W-1..0, tag = remaining upper bits, line invalid or tag different) sees `req_ready` low for exactly FILL_LAT cycles. A load miss then returns the next-level memory word.
- R9: A store that misses writes its merged line into the cache during miss handling. An immediately following load of that address hits with no stall and returns the stored bytes.
- R10: When a miss replaces the line that the pending entry belongs to, the entry is written before the refill. The refilled line then holds only the new address's data.
- R11: Every accepted store also updates next-level memory. A later miss to an evicted address returns the last stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid is also high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_be | input | 4 | Byte-lane mask (lane k = bits 8k+7..8k) |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Load data |

## Verification
The hardest case to reach from the ports is a refill that evicts the very line a pending entry belongs to. It only arises when a store hit is followed at once by a miss to the same index under a different tag, with no idle cycle between them. An idle cycle would drain the entry early. The directed sequence presents exactly that pair back to back and then reads both addresses. The random phase confines addresses to four tags over sixteen indexes and rarely inserts gaps, so same-line and same-word collisions between pending stores, loads and refills occur often.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  localparam int unsigned DW   = 32;
  localparam int unsigned BE_W = DW / 8;

  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_FILL = 1'b1
  } dsb_state_e;

  // Byte-lane merge: lanes set in be take from nw, others from old.
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                               input logic [DW-1:0] nw,
                                               input logic [BE_W-1:0] be);
    logic [DW-1:0] res;
    for (int k = 0; k < BE_W; k++) begin
      res[8*k +: 8] = be[k] ? nw[8*k +: 8] : old[8*k +: 8];
    end
    return res;
  endfunction

  // Reset contents of the next-level memory.
  function automatic logic [DW-1:0] init_word(input int unsigned a);
    logic [DW-1:0] w;
    w = a;
    return w * 32'h0101_0101;
  endfunction

endpackage

// File: rtl/dsb_tag_array.sv
module dsb_tag_array #(
  parameter int unsigned INDEX_W = 4,
  parameter int unsigned TAG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_index,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [TAG_W-1:0]   wr_tag
);
  localparam int unsigned LINES = 1 << INDEX_W;

  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_index] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_index] <= wr_tag;
  end

  assign rd_valid = vld_q[rd_index];
  assign rd_tag   = tag_q[rd_index];
endmodule

// File: rtl/dsb_data_array.sv
module dsb_data_array
  import dsb_pkg::*;
#(
  parameter int unsigned INDEX_W = 4
) (
  input  logic               clk,
  input  logic [INDEX_W-1:0] rd_index,
  output logic [DW-1:0]      rd_data,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [BE_W-1:0]    wr_be,
  input  logic [DW-1:0]      wr_data
);
  localparam int unsigned LINES = 1 << INDEX_W;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    logic [7:0] lane_q [LINES];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) lane_q[wr_index] <= wr_data[8*g +: 8];
    end
    assign rd_data[8*g +: 8] = lane_q[rd_index];
  end
endmodule

// File: rtl/dsb_backing_mem.sv
module dsb_backing_mem
  import dsb_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [BE_W-1:0] wr_be,
  input  logic [DW-1:0]   wr_data
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= init_word(i);
    end else if (wr_en) begin
      mem_q[wr_addr] <= lane_merge(mem_q[wr_addr], wr_data, wr_be);
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/deferred_store_cache.sv
module deferred_store_cache
  import dsb_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned INDEX_W  = 4,
  parameter int unsigned FILL_LAT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [3:0]      req_be,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_rdata
);
  localparam int unsigned TAG_W = AW - INDEX_W;
  localparam int unsigned CNT_W = (FILL_LAT > 1) ? $clog2(FILL_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILL_LAT - 1);

  dsb_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  // Pending entry
  logic            buf_valid_q;
  logic [AW-1:0]   buf_addr_q;
  logic [BE_W-1:0] buf_be_q;
  logic [DW-1:0]   buf_data_q;

  logic [INDEX_W-1:0] req_index;
  logic [TAG_W-1:0]   req_tag;
  logic               tag_valid;
  logic [TAG_W-1:0]   tag_rd;
  logic               line_hit;
  logic               hazard;
  logic               fill_done;
  logic               fill_wr;
  logic               drain;
  logic               buf_load;
  logic               go_fill;
  logic               accept;
  logic [DW-1:0]      arr_rd;
  logic [DW-1:0]      mem_rd;
  logic [DW-1:0]      fill_line;

  logic               dw_en;
  logic [INDEX_W-1:0] dw_index;
  logic [BE_W-1:0]    dw_be;
  logic [DW-1:0]      dw_data;

  assign req_index = req_addr[INDEX_W-1:0];
  assign req_tag   = req_addr[AW-1:INDEX_W];
  assign line_hit  = tag_valid && (tag_rd == req_tag);
  assign hazard    = buf_valid_q && !req_write && (buf_addr_q == req_addr)
                     && ((buf_be_q & req_be) != '0);
  assign fill_done = (state_q == ST_FILL) && (cnt_q == CNT_LAST);
  assign accept    = req_valid && req_ready;

  // Control: one request per cycle in RUN, fixed wait in FILL.
  always_comb begin
    req_ready = 1'b0;
    drain     = 1'b0;
    buf_load  = 1'b0;
    go_fill   = 1'b0;
    fill_wr   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (!req_valid) begin
          req_ready = 1'b1;
          drain     = buf_valid_q;          // free data-array cycle
        end else if (!line_hit) begin
          go_fill   = 1'b1;
          drain     = buf_valid_q;          // empties before any refill
        end else if (req_write) begin
          req_ready = 1'b1;
          drain     = buf_valid_q;          // older entry uses this slot
          buf_load  = 1'b1;
        end else if (hazard) begin
          drain     = 1'b1;                 // one-cycle stall
        end else begin
          req_ready = 1'b1;
        end
      end
      ST_FILL: begin
        req_ready = fill_done;
        fill_wr   = fill_done && req_valid;
      end
    endcase
  end

  assign fill_line = req_write ? lane_merge(mem_rd, req_wdata, req_be) : mem_rd;

  assign dw_en    = drain || fill_wr;
  assign dw_index = fill_wr ? req_index : buf_addr_q[INDEX_W-1:0];
  assign dw_be    = fill_wr ? {BE_W{1'b1}} : buf_be_q;
  assign dw_data  = fill_wr ? fill_line : buf_data_q;

  dsb_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_index (req_index),
    .rd_valid (tag_valid),
    .rd_tag   (tag_rd),
    .wr_en    (fill_wr),
    .wr_index (req_index),
    .wr_tag   (req_tag)
  );

  dsb_data_array #(.INDEX_W(INDEX_W)) u_data (
    .clk      (clk),
    .rd_index (req_index),
    .rd_data  (arr_rd),
    .wr_en    (dw_en),
    .wr_index (dw_index),
    .wr_be    (dw_be),
    .wr_data  (dw_data)
  );

  dsb_backing_mem #(.AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (req_addr),
    .rd_data (mem_rd),
    .wr_en   (accept && req_write),
    .wr_addr (req_addr),
    .wr_be   (req_be),
    .wr_data (req_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (go_fill) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
          end
        end
        ST_FILL: begin
          if (fill_wr)        state_q <= ST_RUN;
          else if (!fill_done) cnt_q  <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid_q <= 1'b0;
      buf_addr_q  <= '0;
      buf_be_q    <= '0;
      buf_data_q  <= '0;
    end else begin
      if (drain) buf_valid_q <= 1'b0;
      if (buf_load) begin
        buf_valid_q <= 1'b1;
        buf_addr_q  <= req_addr;
        buf_be_q    <= req_be;
        buf_data_q  <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept && !req_write;
      if (accept && !req_write)
        rsp_rdata <= (state_q == ST_FILL) ? mem_rd : arr_rd;
    end
  end
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [3:0]    req_be,
  input logic          rsp_valid,
  input logic          buf_valid,
  input logic [AW-1:0] buf_addr,
  input logic [3:0]    buf_be,
  input logic          in_fill,
  input logic          refill_wr
);
  logic load_acc;
  logic overlap_ld;
  assign load_acc   = req_valid && req_ready && !req_write;
  assign overlap_ld = req_valid && !req_write && buf_valid
                      && (buf_addr == req_addr) && ((buf_be & req_be) != 4'h0);

  a_r2_rsp_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> rsp_valid);

  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !load_acc |=> !rsp_valid);

  a_r3_store_hit_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && !in_fill)
      |=> (buf_valid && buf_addr == $past(req_addr) && buf_be == $past(req_be)));

  a_r6_overlap_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_ld |-> !req_ready);

  a_r6_overlap_drains: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_ld |=> !buf_valid);

  a_r10_refill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    refill_wr |-> !buf_valid);

  a_r8_fill_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill |-> !buf_valid);
endmodule

bind deferred_store_cache dsb_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_be    (req_be),
  .rsp_valid (rsp_valid),
  .buf_valid (buf_valid_q),
  .buf_addr  (buf_addr_q),
  .buf_be    (buf_be_q),
  .in_fill   (state_q == dsb_pkg::ST_FILL),
  .refill_wr (fill_wr)
);

// File: tb/sim_deferred_store_cache.sv
`timescale 1ns/1ps
module sim_deferred_store_cache;
  localparam int unsigned AW       = 8;
  localparam int unsigned INDEX_W  = 4;
  localparam int unsigned FILL_LAT = 4;
  localparam int unsigned WORDS    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_be = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;
  logic [31:0] ref_mem [WORDS];

  always #2 clk = ~clk;

  deferred_store_cache #(.AW(AW), .INDEX_W(INDEX_W), .FILL_LAT(FILL_LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = be[k] ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [3:0] be,
                      input logic [31:0] d, input string req, output int stalls);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    stalls = 0;
    forever begin
      #1;
      if (req_ready) break;
      stalls++;
      if (stalls > 500) begin
        chk({req, " watchdog"}, 32'(stalls), 32'd0);
        finish_run();
      end
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      ref_mem[a] = (ref_mem[a] & ~be_mask(be)) | (d & be_mask(be));
    end else begin
      chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      chk({req, " data"}, rsp_rdata & be_mask(be), ref_mem[a] & be_mask(be));
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    chk("global watchdog", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    int s;
    for (int i = 0; i < WORDS; i++) ref_mem[i] = 32'(i) * 32'h0101_0101;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 ready after reset", 32'(req_ready), 32'd1);
    chk("R1 no rsp after reset", 32'(rsp_valid), 32'd0);
    @(negedge clk);

    // R1/R8: first access misses and returns reset contents
    xfer(0, 8'h13, 4'hF, 0, "R8 load miss", s);
    chk("R8 miss stall", 32'(s), FILL_LAT);
    xfer(0, 8'h13, 4'hF, 0, "R2 load hit", s);
    chk("R2 hit no stall", 32'(s), 32'd0);

    // R3 then R6: overlapping load right behind a store hit
    xfer(1, 8'h13, 4'hF, 32'hDEAD_BEEF, "R3 store hit", s);
    chk("R3 store hit no stall", 32'(s), 32'd0);
    xfer(0, 8'h13, 4'h1, 0, "R6 overlap load", s);
    chk("R6 one-cycle stall", 32'(s), 32'd1);

    // R7: disjoint lanes
    xfer(1, 8'h13, 4'h3, 32'h1234_5678, "R7 store", s);
    xfer(0, 8'h13, 4'hC, 0, "R7 disjoint load", s);
    chk("R7 no stall", 32'(s), 32'd0);

    // R5: idle cycle drains the entry
    xfer(1, 8'h13, 4'h6, 32'hA5A5_A5A5, "R5 store", s);
    idle();
    xfer(0, 8'h13, 4'hF, 0, "R5 load after idle", s);
    chk("R5 no stall", 32'(s), 32'd0);

    // R4: back-to-back store hits
    xfer(1, 8'h13, 4'hF, 32'h0BAD_F00D, "R4 store a", s);
    chk("R4 store a no stall", 32'(s), 32'd0);
    xfer(1, 8'h13, 4'h8, 32'h7700_0000, "R4 store b", s);
    chk("R4 store b no stall", 32'(s), 32'd0);
    xfer(1, 8'h13, 4'h1, 32'h0000_0042, "R4 store c", s);
    chk("R4 store c no stall", 32'(s), 32'd0);
    xfer(0, 8'h13, 4'hF, 0, "R4 readback", s);

    // R9: store miss allocates
    xfer(1, 8'h25, 4'h5, 32'h1111_2222, "R9 store miss", s);
    chk("R9 miss stall", 32'(s), FILL_LAT);
    xfer(0, 8'h25, 4'hF, 0, "R9 load after store miss", s);
    chk("R9 hit no stall", 32'(s), 32'd0);

    // R10/R11: store hit, then at once a miss on the same line
    xfer(1, 8'h13, 4'hF, 32'hCAFE_0001, "R10 store", s);
    xfer(0, 8'h23, 4'hF, 0, "R10 conflicting miss", s);
    chk("R10 miss stall", 32'(s), FILL_LAT);
    xfer(0, 8'h23, 4'hF, 0, "R10 refilled line clean", s);
    xfer(0, 8'h13, 4'hF, 0, "R11 evicted store visible", s);
    chk("R11 reload is miss", 32'(s), FILL_LAT);

    // Random mix over 4 tags x 16 indexes (R2 R4 R6 R8 R11)
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      logic [3:0]    be;
      a  = AW'($urandom % 64);
      be = 4'($urandom % 15) + 4'd1;
      if ($urandom % 2 == 0) xfer(1, a, be, $urandom, "R2 random store", s);
      else                   xfer(0, a, be, 0, "R2 random load", s);
      if ($urandom % 8 == 0) idle();
    end

    idle();
    finish_run();
  end
endmodule